// File: doc/BRIEF.md
# Byte-Masked One-Time-Programmable Page Controller

This block is a register-mapped controller in front of a page store of 512 pages, each 128 bits wide. Software loads four 32-bit staging words, picks which of the 16 page bytes take part through a 16-bit lane mask, and then writes a command register. That register holds a page number and two command bits. A store command copies the enabled staging bytes into the chosen page. A fetch command copies the enabled page bytes back into the staging words. Bytes that are not enabled stay as they were at the destination. Every command write sets a sticky completion flag, which software clears by writing a one to it. The flag also drives the `otp_done` output.

Register traffic uses a small synchronous request/response bus. A request is held with `req_valid` until the cycle in which `req_ready` is high, and is accepted in that cycle. The block drops `req_ready` for exactly one cycle after it accepts a command write, because the page operation runs in that cycle. Responses cannot be back-pressured. `rsp_valid` pulses exactly one cycle after each accepted request and carries `rsp_rdata` together with a two-bit outcome code. The code is 0 for success, 1 for an access size other than 2 or 4, 2 for an unmapped offset, and 3 for a size that does not suit the register addressed. A request that ends with a nonzero code changes no state.

Top module: `otp_page_ctrl`

## Requirements
- R1: After reset the lane mask reads 0xFFFF and the timing word reads 0x00001485. The command register, the status register and all four staging words read 0, `otp_done` is low, and every page holds all zeros.
- R2: The registers sit at fixed offsets: command 0x00, lane mask 0x04, status 0x08 (each 16 bits, returned in `rsp_rdata[15:0]` with the upper bits zero), timing 0x0C, and staging words 0 to 3 at 0x80, 0x84, 0x88 and 0x8C (each 32 bits). Timing is a plain read/write word.
- R3: A request whose size is neither 2 nor 4 returns code 1 at any offset, including unmapped ones. This check wins over the unmapped-offset check.
- R4: A request of size 2 or 4 to an unmapped offset returns code 2 and leaves all registers unchanged.
- R5: A 4-byte access to a 16-bit register, or a 2-byte access to a 32-bit register, returns code 3. Such a write changes nothing.
- R6: A write to the command register keeps only the bits under mask 0x39FF. Bit 15 (store) and bit 14 (fetch) act on the write but always read back as 0. Bits [8:0] select the page (0 to 511).
- R7: A store command copies byte i (i = 0 to 15) of the staging words into byte i of the selected page when lane-mask bit i is 1. Byte i is bits [8*(i%4)+7 : 8*(i%4)] of staging word i/4.
- R8: A fetch command copies byte i of the selected page into byte i of the staging words when lane-mask bit i is 1. Disabled staging bytes keep their values.
- R9: When store and fetch are both set in one command write, the store takes place first, so the fetch returns the page content as updated by that store.
- R10: Each accepted command write sets status bit 0, and `otp_done` follows status bit 0. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R11: `rsp_valid` is high exactly one cycle after each accepted request and at no other time. `req_ready` is low for exactly the one cycle that follows an accepted command write, and high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present, held until accepted |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 8 | Byte offset of the register |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data, 16-bit registers use bits [15:0] |
| rsp_valid | output | 1 | Response pulse, one cycle after acceptance |
| rsp_rdata | output | 32 | Read data, zero for writes and errors |
| rsp_code | output | 2 | 0 ok, 1 bad size, 2 unmapped, 3 width mismatch |
| otp_done | output | 1 | Completion flag (status bit 0) |

## Verification
The ports offer no direct way to observe whether a combined store-and-fetch orders its two halves correctly. The bench therefore arranges a case in which the two orders give different results. It stages nonzero words and narrows the lane mask to the low four bytes. It then issues a combined command to a page that has never been written. A fetch that ran first would return zeros into staging word 0. The bench then widens the mask and fetches the page again, which shows that only the enabled bytes were stored. Masked fetches from unwritten pages with a sparse lane mask also confirm the byte-to-word ordering, and the bench checks that masked-off staging bytes are left intact.

// File: rtl/otp_pkg.sv
package otp_pkg;

  typedef enum logic [1:0] {
    RSP_OK       = 2'd0,
    RSP_BADSIZE  = 2'd1,
    RSP_NOREG    = 2'd2,
    RSP_BADWIDTH = 2'd3
  } rsp_code_e;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CMD,
    SEL_LANE,
    SEL_STAT,
    SEL_TIME,
    SEL_STAGE
  } reg_sel_e;

  localparam logic [7:0]  OFS_CMD    = 8'h00;
  localparam logic [7:0]  OFS_LANE   = 8'h04;
  localparam logic [7:0]  OFS_STAT   = 8'h08;
  localparam logic [7:0]  OFS_TIME   = 8'h0C;
  localparam logic [7:0]  OFS_STAGE0 = 8'h80;

  localparam logic [15:0] CMD_KEEP   = 16'h39FF;
  localparam int          CMD_STORE  = 15;
  localparam int          CMD_FETCH  = 14;
  localparam logic [15:0] LANE_RESET = 16'hFFFF;
  localparam logic [31:0] TIME_RESET = 32'h0000_1485;

endpackage

// File: rtl/otp_bus_decode.sv
module otp_bus_decode
  import otp_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int STAGE_WORDS = 4,
  parameter int IDX_W = $clog2(STAGE_WORDS)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        size,
  output reg_sel_e          sel,
  output logic [IDX_W-1:0]  stage_idx,
  output rsp_code_e         code
);

  logic narrow;

  always_comb begin
    sel       = SEL_NONE;
    stage_idx = '0;
    narrow    = 1'b0;
    if (addr == ADDR_W'(OFS_CMD)) begin
      sel = SEL_CMD;  narrow = 1'b1;
    end else if (addr == ADDR_W'(OFS_LANE)) begin
      sel = SEL_LANE; narrow = 1'b1;
    end else if (addr == ADDR_W'(OFS_STAT)) begin
      sel = SEL_STAT; narrow = 1'b1;
    end else if (addr == ADDR_W'(OFS_TIME)) begin
      sel = SEL_TIME;
    end else begin
      for (int w = 0; w < STAGE_WORDS; w++) begin
        if (addr == ADDR_W'(OFS_STAGE0) + ADDR_W'(4 * w)) begin
          sel       = SEL_STAGE;
          stage_idx = IDX_W'(w);
        end
      end
    end

    if (size != 3'd2 && size != 3'd4)
      code = RSP_BADSIZE;
    else if (sel == SEL_NONE)
      code = RSP_NOREG;
    else if (narrow != (size == 3'd2))
      code = RSP_BADWIDTH;
    else
      code = RSP_OK;
  end

endmodule

// File: rtl/otp_byte_merge.sv
module otp_byte_merge #(
  parameter int BYTES = 16
) (
  input  logic [BYTES*8-1:0] base,
  input  logic [BYTES*8-1:0] repl,
  input  logic [BYTES-1:0]   en,
  output logic [BYTES*8-1:0] result
);

  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    assign result[8*b +: 8] = en[b] ? repl[8*b +: 8] : base[8*b +: 8];
  end

endmodule

// File: rtl/otp_page_store.sv
module otp_page_store #(
  parameter int PAGES  = 512,
  parameter int PAGE_W = 128,
  parameter int AW     = $clog2(PAGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     page,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] wr_data,
  output logic [PAGE_W-1:0] rd_data
);

  logic [PAGE_W-1:0] cells [PAGES];
  logic [PAGES-1:0]  touched;

  always_ff @(posedge clk) begin
    if (wr_en) cells[page] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     touched <= '0;
    else if (wr_en) touched[page] <= 1'b1;
  end

  assign rd_data = touched[page] ? cells[page] : '0;

endmodule

// File: rtl/otp_page_ctrl.sv
module otp_page_ctrl
  import otp_pkg::*;
#(
  parameter int PAGES       = 512,
  parameter int PAGE_BYTES  = 16,
  parameter int ADDR_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic [1:0]        rsp_code,
  output logic              otp_done
);

  localparam int PAGE_W      = PAGE_BYTES * 8;
  localparam int STAGE_WORDS = PAGE_W / 32;
  localparam int IDX_W       = $clog2(STAGE_WORDS);
  localparam int PAGE_AW     = $clog2(PAGES);

  logic [15:0]           cmd_q;
  logic [PAGE_BYTES-1:0] lane_q;
  logic [15:0]           stat_q;
  logic [31:0]           time_q;
  logic [PAGE_W-1:0]     stage_q;
  logic                  busy_q;
  logic                  op_store_q, op_fetch_q;
  logic [PAGE_AW-1:0]    op_page_q;

  reg_sel_e              sel;
  logic [IDX_W-1:0]      stage_idx;
  rsp_code_e             code;
  logic                  accept, wr_ok, rd_ok;
  logic [31:0]           rd_mux;

  logic [PAGE_W-1:0]     page_old, page_new, fetch_src, stage_next;

  otp_bus_decode #(.ADDR_W(ADDR_W), .STAGE_WORDS(STAGE_WORDS)) u_decode (
    .addr(req_addr), .size(req_size),
    .sel(sel), .stage_idx(stage_idx), .code(code)
  );

  otp_page_store #(.PAGES(PAGES), .PAGE_W(PAGE_W)) u_store (
    .clk(clk), .rst_n(rst_n), .page(op_page_q),
    .wr_en(busy_q & op_store_q), .wr_data(page_new), .rd_data(page_old)
  );

  otp_byte_merge #(.BYTES(PAGE_BYTES)) u_store_merge (
    .base(page_old), .repl(stage_q), .en(lane_q), .result(page_new)
  );

  assign fetch_src = op_store_q ? page_new : page_old;

  otp_byte_merge #(.BYTES(PAGE_BYTES)) u_fetch_merge (
    .base(stage_q), .repl(fetch_src), .en(lane_q), .result(stage_next)
  );

  assign req_ready = ~busy_q;
  assign accept    = req_valid & req_ready;
  assign wr_ok     = accept & req_write & (code == RSP_OK);
  assign rd_ok     = accept & ~req_write & (code == RSP_OK);

  always_comb begin
    case (sel)
      SEL_CMD:   rd_mux = {16'h0, cmd_q};
      SEL_LANE:  rd_mux = 32'(lane_q);
      SEL_STAT:  rd_mux = {16'h0, stat_q};
      SEL_TIME:  rd_mux = time_q;
      SEL_STAGE: rd_mux = stage_q[32*stage_idx +: 32];
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q      <= '0;
      lane_q     <= PAGE_BYTES'(LANE_RESET);
      stat_q     <= '0;
      time_q     <= TIME_RESET;
      stage_q    <= '0;
      busy_q     <= 1'b0;
      op_store_q <= 1'b0;
      op_fetch_q <= 1'b0;
      op_page_q  <= '0;
    end else if (busy_q) begin
      busy_q    <= 1'b0;
      stat_q[0] <= 1'b1;
      if (op_fetch_q) stage_q <= stage_next;
    end else if (wr_ok) begin
      case (sel)
        SEL_CMD: begin
          cmd_q      <= req_wdata[15:0] & CMD_KEEP;
          op_page_q  <= req_wdata[PAGE_AW-1:0];
          op_store_q <= req_wdata[CMD_STORE];
          op_fetch_q <= req_wdata[CMD_FETCH];
          busy_q     <= 1'b1;
        end
        SEL_LANE:  lane_q <= req_wdata[PAGE_BYTES-1:0];
        SEL_STAT:  stat_q <= stat_q & ~req_wdata[15:0];
        SEL_TIME:  time_q <= req_wdata;
        SEL_STAGE: stage_q[32*stage_idx +: 32] <= req_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_code  <= '0;
    end else begin
      rsp_valid <= accept;
      rsp_rdata <= rd_ok ? rd_mux : '0;
      rsp_code  <= accept ? code : RSP_OK;
    end
  end

  assign otp_done = stat_q[0];

endmodule

// File: rtl/otp_page_ctrl_chk.sv
module otp_page_ctrl_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [2:0]        req_size,
  input logic              rsp_valid,
  input logic [1:0]        rsp_code,
  input logic              otp_done,
  input logic [15:0]       lane_q,
  input logic              busy_q
);

  logic acc;
  assign acc = req_valid && req_ready;

  p_rsp_after_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid);

  p_no_stray_rsp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !rsp_valid);

  p_stall_after_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write && req_addr == '0 && req_size == 3'd2) |=> !req_ready);

  p_done_after_op_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> otp_done);

  p_done_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (otp_done && !(acc && req_write && req_addr == ADDR_W'(8'h08))) |=> otp_done);

  p_bad_size_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_size != 3'd2 && req_size != 3'd4) |=> rsp_code == 2'd1);

  p_wide_lane_write_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write && req_addr == ADDR_W'(8'h04) && req_size == 3'd4)
      |=> ($stable(lane_q) && rsp_code == 2'd3));

endmodule

bind otp_page_ctrl otp_page_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
  .rsp_valid(rsp_valid), .rsp_code(rsp_code), .otp_done(otp_done),
  .lane_q(lane_q), .busy_q(busy_q)
);

// File: tb/otp_page_ctrl_bench.sv
`timescale 1ns/1ps
module otp_page_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [2:0]  req_size = 3'd2;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [1:0]  rsp_code;
  logic        otp_done;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  otp_page_ctrl u_otp_page_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_code(rsp_code), .otp_done(otp_done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus(input logic wr, input logic [7:0] a, input logic [2:0] sz,
                     input logic [31:0] wd, output logic [31:0] rd, output logic [1:0] cd);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    if (!rsp_valid) begin
      checks++; fails++;
      $display("FAIL R11: actual=rsp_valid 0 expected=1");
    end
    rd = rsp_rdata; cd = rsp_code;
  endtask

  task automatic wr(input string req, input logic [7:0] a, input logic [2:0] sz, input logic [31:0] d);
    logic [31:0] r; logic [1:0] c;
    bus(1'b1, a, sz, d, r, c);
    check(req, 32'(c), 32'd0);
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [2:0] sz, input logic [31:0] exp);
    logic [31:0] r; logic [1:0] c;
    bus(1'b0, a, sz, 32'h0, r, c);
    check(req, 32'(c), 32'd0);
    check(req, r, exp);
  endtask

  task automatic code_chk(input string req, input logic w, input logic [7:0] a, input logic [2:0] sz,
                          input logic [31:0] d, input logic [1:0] exp);
    logic [31:0] r; logic [1:0] c;
    bus(w, a, sz, d, r, c);
    check(req, 32'(c), 32'(exp));
  endtask

  task automatic stage(input logic [127:0] v);
    for (int w = 0; w < 4; w++) wr("R2", 8'h80 + 8'(4 * w), 3'd4, v[32*w +: 32]);
  endtask

  task automatic stage_chk(input string req, input logic [127:0] v);
    for (int w = 0; w < 4; w++) rd_chk(req, 8'h80 + 8'(4 * w), 3'd4, v[32*w +: 32]);
  endtask

  task automatic t_reset;
    rd_chk("R1", 8'h04, 3'd2, 32'h0000_FFFF);
    rd_chk("R1", 8'h0C, 3'd4, 32'h0000_1485);
    rd_chk("R1", 8'h00, 3'd2, 32'h0);
    rd_chk("R1", 8'h08, 3'd2, 32'h0);
    stage_chk("R1", 128'h0);
    check("R1", 32'(otp_done), 32'd0);
  endtask

  task automatic t_map_and_errors;
    wr("R2", 8'h0C, 3'd4, 32'hCAFE_0001);
    rd_chk("R2", 8'h0C, 3'd4, 32'hCAFE_0001);
    stage(128'h4444_4444_3333_3333_2222_2222_1111_1111);
    stage_chk("R2", 128'h4444_4444_3333_3333_2222_2222_1111_1111);
    code_chk("R3", 1'b0, 8'h40, 3'd1, 32'h0, 2'd1);
    code_chk("R3", 1'b1, 8'h00, 3'd3, 32'hFFFF, 2'd1);
    code_chk("R3", 1'b0, 8'h80, 3'd0, 32'h0, 2'd1);
    code_chk("R4", 1'b1, 8'h40, 3'd4, 32'h1234_5678, 2'd2);
    code_chk("R4", 1'b1, 8'h90, 3'd4, 32'h1234_5678, 2'd2);
    stage_chk("R4", 128'h4444_4444_3333_3333_2222_2222_1111_1111);
    code_chk("R5", 1'b1, 8'h04, 3'd4, 32'h0, 2'd3);
    rd_chk("R5", 8'h04, 3'd2, 32'h0000_FFFF);
    code_chk("R5", 1'b1, 8'h84, 3'd2, 32'h0, 2'd3);
    rd_chk("R5", 8'h84, 3'd4, 32'h2222_2222);
    code_chk("R5", 1'b1, 8'h00, 3'd4, 32'hC005, 2'd3);
    check("R5", 32'(otp_done), 32'd0);
  endtask

  task automatic t_cmd_mask_done;
    stage(128'hDDDD_0004_CCCC_0003_BBBB_0002_AAAA_0001);
    wr("R6", 8'h00, 3'd2, 32'h0000_FFFF);
    rd_chk("R6", 8'h00, 3'd2, 32'h0000_39FF);
    check("R10", 32'(otp_done), 32'd1);
    rd_chk("R10", 8'h08, 3'd2, 32'h1);
    wr("R10", 8'h08, 3'd2, 32'h0000_FFFE);
    check("R10", 32'(otp_done), 32'd1);
    wr("R10", 8'h08, 3'd2, 32'h0000_0001);
    check("R10", 32'(otp_done), 32'd0);
    rd_chk("R10", 8'h08, 3'd2, 32'h0);
    stage(128'h0);
    wr("R8", 8'h00, 3'd2, 32'h0000_41FF);
    stage_chk("R6", 128'hDDDD_0004_CCCC_0003_BBBB_0002_AAAA_0001);
  endtask

  task automatic t_store_fetch;
    stage(128'h0F0E0D0C_0B0A0908_07060504_03020100);
    wr("R7", 8'h00, 3'd2, 32'h0000_8005);
    stage(128'h0);
    wr("R8", 8'h00, 3'd2, 32'h0000_4005);
    stage_chk("R7", 128'h0F0E0D0C_0B0A0908_07060504_03020100);
    stage(128'hF0F0F0F0_F0F0F0F0_F0F0F0F0_F0F0F0F0);
    wr("R7", 8'h04, 3'd2, 32'h0000_0F0F);
    wr("R7", 8'h00, 3'd2, 32'h0000_8005);
    wr("R7", 8'h04, 3'd2, 32'h0000_FFFF);
    stage(128'h0);
    wr("R7", 8'h00, 3'd2, 32'h0000_4005);
    stage_chk("R7", 128'h0F0E0D0C_F0F0F0F0_07060504_F0F0F0F0);
  endtask

  task automatic t_masked_fetch;
    stage(128'hAAAAAAAA_AAAAAAAA_AAAAAAAA_AAAAAAAA);
    wr("R8", 8'h04, 3'd2, 32'h0000_8001);
    wr("R8", 8'h00, 3'd2, 32'h0000_4007);
    stage_chk("R8", 128'h00AAAAAA_AAAAAAAA_AAAAAAAA_AAAAAA00);
    wr("R8", 8'h04, 3'd2, 32'h0000_FFFF);
  endtask

  task automatic t_both;
    stage(128'h99999999_88888888_77777777_5A5A5A5A);
    wr("R9", 8'h04, 3'd2, 32'h0000_000F);
    wr("R9", 8'h00, 3'd2, 32'h0000_C009);
    stage_chk("R9", 128'h99999999_88888888_77777777_5A5A5A5A);
    wr("R9", 8'h04, 3'd2, 32'h0000_FFFF);
    wr("R9", 8'h00, 3'd2, 32'h0000_4009);
    stage_chk("R9", 128'h00000000_00000000_00000000_5A5A5A5A);
  endtask

  task automatic t_handshake;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h00; req_size = 3'd2; req_wdata = 32'h0000_0003;
    @(negedge clk);
    req_valid = 1'b0;
    check("R11", 32'(rsp_valid), 32'd1);
    check("R11", 32'(req_ready), 32'd0);
    @(negedge clk);
    check("R11", 32'(req_ready), 32'd1);
    check("R11", 32'(rsp_valid), 32'd0);
    check("R10", 32'(otp_done), 32'd1);
  endtask

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_map_and_errors();
    t_cmd_mask_done();
    t_store_fetch();
    t_masked_fetch();
    t_both();
    t_handshake();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule